// File: doc/BRIEF.md
# Watchdog Timer with Reset-Vector-Aliased Service Location

This block is a computer-operating-properly watchdog. A free-running counter advances on each cycle on which an enable tick from the crystal-derived time base is present. If software lets it reach its terminal count, the block issues a single-cycle reset request. Software keeps the system alive by writing to the top address of the memory map. That is the same location that holds the low byte of the reset vector. Any write there restarts the timeout. A read of that location returns the vector byte supplied by the boot ROM and never any watchdog state.

Several inputs gate the count:
- **Stop mode** freezes the counter. While stop mode lasts, the block also raises a clear request for the upstream system prescaler.
- **Monitor mode** suppresses counting when an elevated-voltage flag is present on either the interrupt pin or the reset pin.
- **Break state** suppresses counting when the elevated-voltage flag is present on the reset pin.

Wait mode needs no input: the counter keeps running, so software must keep servicing it from interrupt code. Nothing in the write data is examined, so the data bus is not connected. The block raises no interrupt and no DMA request. Its only effect is the reset request.

Top module: `wdog_vec_svc`

## Requirements
- R1: A cycle with `bus_wr` high and `bus_addr` equal to `SVC_ADDR` (all ones, 0xFFFF by default) clears the counter, so a full period of 2^CNT_W enabled ticks must pass before the next reset request.
- R2: Without service, `wdog_rst` rises on the cycle after the 2^CNT_W-th enabled tick, stays high for exactly one cycle, and the count restarts from zero.
- R3: `bus_rdata` equals `vec_lo` while `bus_rd` is high and `bus_addr` equals `SVC_ADDR`; otherwise it is zero. The path is combinational.
- R4: Reads of any address, and writes to any address other than `SVC_ADDR`, leave the counter unaffected.
- R5: While `rst_n` is low (synchronous, active low), the counter clears and `wdog_rst` is low. After release, the first request comes only after a full period.
- R6: If a service write coincides with the terminal-count tick, the service wins: no request is issued and the count restarts.
- R7: While `stop_mode` is high, the counter holds its value and `presc_clr` is high. `presc_clr` is low otherwise.
- R8: While `mon_mode` is high together with `irq_hv` or `rst_hv`, the counter holds. `mon_mode` alone does not stop counting.
- R9: While `brk_act` and `rst_hv` are both high, the counter holds. `brk_act` alone, or with `irq_hv` only, does not stop counting.
- R10: The counter advances only on cycles with `cnt_tick` high. A cycle with `cnt_tick` low holds the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_tick | input | 1 | Enable tick from the crystal-derived time base |
| bus_addr | input | ADDR_W | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| vec_lo | input | DATA_W | Low byte of the reset vector from the boot ROM |
| bus_rdata | output | DATA_W | Read data for the service location, zero elsewhere |
| stop_mode | input | 1 | Stop mode active |
| mon_mode | input | 1 | Monitor mode active |
| brk_act | input | 1 | Break interrupt in progress |
| irq_hv | input | 1 | Elevated voltage sensed on the interrupt pin |
| rst_hv | input | 1 | Elevated voltage sensed on the reset pin |
| presc_clr | output | 1 | Request to clear the upstream system prescaler |
| wdog_rst | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that the mode and elevated-voltage inputs are synchronous to `clk` and settled before each edge. They also assume `CNT_W` is at least 2, so that a request can never be followed directly by another one. The checker derives the expected enable from the ports alone. It is therefore valid for any stimulus, including service writes that land while counting is suppressed. The bench drives all inputs at the falling edge only. It uses a six-bit counter so that many timeouts fit into the run. Its random mix keeps service writes rare enough that both timeouts and coincident service-at-terminal-count cycles occur.

// File: rtl/wdog_pkg.sv
// Package: wdog_pkg
// Shared types for the watchdog. The gating conditions are grouped in a
// struct so the gate module takes one typed input.
package wdog_pkg;

    // Operating-state inputs that can suppress counting
    typedef struct packed {
        logic stop;    // stop mode: time base gated off
        logic mon;     // monitor mode
        logic brk;     // break interrupt in progress
        logic irq_hv;  // elevated voltage on the interrupt pin
        logic rst_hv;  // elevated voltage on the reset pin
    } wdog_mode_t;

endpackage

// File: rtl/wdog_addr_dec.sv
// Module: wdog_addr_dec
// Decodes the service location. A write there is a service strike. A read
// there returns the reset-vector low byte.
// Assumes: single-cycle bus strobes, data combinationally valid.
module wdog_addr_dec #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}}
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] vec_lo,
    output logic              svc_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic hit;

    // Address match and read mux for the shared location
    always_comb begin
        hit       = (bus_addr == SVC_ADDR);
        svc_wr    = hit & bus_wr;
        bus_rdata = (hit & bus_rd) ? vec_lo : '0;
    end
endmodule

// File: rtl/wdog_cnt_gate.sv
// Module: wdog_cnt_gate
// Forms the count enable from the time-base tick and the operating state.
// It also issues the prescaler clear request while in stop mode.
// Assumes: all inputs synchronous to the system clock.
module wdog_cnt_gate
    import wdog_pkg::*;
(
    input  logic       cnt_tick,
    input  wdog_mode_t mode,
    output logic       cnt_en,
    output logic       presc_clr
);
    logic mon_off;
    logic brk_off;

    // Suppression terms and the resulting enable
    always_comb begin
        mon_off   = mode.mon & (mode.irq_hv | mode.rst_hv);
        brk_off   = mode.brk & mode.rst_hv;
        cnt_en    = cnt_tick & ~mode.stop & ~mon_off & ~brk_off;
        presc_clr = mode.stop;
    end
endmodule

// File: rtl/wdog_tmo_counter.sv
// Module: wdog_tmo_counter
// Timeout counter. It counts enabled ticks, and on the tick at the all-ones
// value it wraps to zero and raises a one-cycle request. A service strike
// clears it and takes priority over the terminal tick.
// Assumes: synchronous active-low reset, CNT_W >= 2.
module wdog_tmo_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             svc_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tmo_pulse
);
    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    // Count, clear on service, and flag the terminal tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            tmo_pulse <= 1'b0;
        end else begin
            tmo_pulse <= 1'b0;
            if (svc_wr) begin
                cnt_q <= '0;
            end else if (cnt_en) begin
                if (cnt_q == TERM) begin
                    cnt_q     <= '0;
                    tmo_pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_vec_svc.sv
// Module: wdog_vec_svc
// Top of the watchdog. It ties the address decode, the count gate and the
// timeout counter together.
// Assumes: the caller feeds wdog_rst back into the system reset.
module wdog_vec_svc
    import wdog_pkg::*;
#(
    parameter int                CNT_W    = 18,
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] vec_lo,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_mode,
    input  logic              mon_mode,
    input  logic              brk_act,
    input  logic              irq_hv,
    input  logic              rst_hv,
    output logic              presc_clr,
    output logic              wdog_rst
);
    wdog_mode_t       mode;
    logic             svc_wr;
    logic             cnt_en;
    logic [CNT_W-1:0] cnt_q;

    // Group the operating-state pins
    always_comb begin
        mode = '{stop: stop_mode, mon: mon_mode, brk: brk_act,
                 irq_hv: irq_hv, rst_hv: rst_hv};
    end

    wdog_addr_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)) dec_i (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .vec_lo   (vec_lo),
        .svc_wr   (svc_wr),
        .bus_rdata(bus_rdata)
    );

    wdog_cnt_gate gate_i (
        .cnt_tick (cnt_tick),
        .mode     (mode),
        .cnt_en   (cnt_en),
        .presc_clr(presc_clr)
    );

    wdog_tmo_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .svc_wr   (svc_wr),
        .cnt_q    (cnt_q),
        .tmo_pulse(wdog_rst)
    );
endmodule

// File: rtl/wdog_vec_svc_chk.sv
// Module: wdog_vec_svc_chk
// Checker bound to wdog_vec_svc. It recomputes service and enable from the
// ports and checks the counter state and the outputs over time.
module wdog_vec_svc_chk #(
    parameter int                CNT_W    = 18,
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = {ADDR_W{1'b1}}
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] vec_lo,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              stop_mode,
    input logic              mon_mode,
    input logic              brk_act,
    input logic              irq_hv,
    input logic              rst_hv,
    input logic              wdog_rst,
    input logic [CNT_W-1:0]  cnt_q
);
    logic svc;
    logic held;

    // Port-level view of service and suppression
    always_comb begin
        svc  = bus_wr && (bus_addr == SVC_ADDR);
        held = !cnt_tick || stop_mode || (mon_mode && (irq_hv || rst_hv))
               || (brk_act && rst_hv);
    end

    // R1
    svc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (cnt_q == '0 && !wdog_rst));

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    // R3
    rdata_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SVC_ADDR) |-> bus_rdata == vec_lo);

    // R5
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cnt_q == '0 && !wdog_rst));

    // R6
    svc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && cnt_q == {CNT_W{1'b1}}) |=> !wdog_rst);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !svc) |=> ($stable(cnt_q) && !wdog_rst));
endmodule

bind wdog_vec_svc wdog_vec_svc_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .vec_lo(vec_lo), .bus_rdata(bus_rdata),
    .stop_mode(stop_mode), .mon_mode(mon_mode), .brk_act(brk_act),
    .irq_hv(irq_hv), .rst_hv(rst_hv), .wdog_rst(wdog_rst), .cnt_q(cnt_q)
);

// File: tb/wdog_vec_svc_tb_top.sv
// Bench for wdog_vec_svc. It runs directed corner cases followed by seeded
// random traffic, checked against a reference model written from the
// requirements.
module wdog_vec_svc_tb_top;
    localparam int CLK_P = 10;
    localparam int CW    = 6;
    localparam int AW    = 16;
    localparam int DW    = 8;
    localparam int MAXC  = (1 << CW) - 1;
    localparam logic [AW-1:0] SVC = 16'hFFFF;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          rst_n, cnt_tick, bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] vec_lo, bus_rdata;
    logic          stop_mode, mon_mode, brk_act, irq_hv, rst_hv;
    logic          presc_clr, wdog_rst;

    int   n_chk = 0;
    int   n_bad = 0;
    int   ref_cnt = 0;
    logic ref_pulse = 1'b0;

    wdog_vec_svc #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .vec_lo(vec_lo), .bus_rdata(bus_rdata),
        .stop_mode(stop_mode), .mon_mode(mon_mode), .brk_act(brk_act),
        .irq_hv(irq_hv), .rst_hv(rst_hv), .presc_clr(presc_clr), .wdog_rst(wdog_rst)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rdata();
        return (bus_rd && bus_addr == SVC) ? int'(vec_lo) : 0;
    endfunction

    // Reference model, advanced once per rising edge
    task automatic model_edge();
        logic svc, en;
        svc = bus_wr && (bus_addr == SVC);
        en  = cnt_tick && !stop_mode && !(mon_mode && (irq_hv || rst_hv))
              && !(brk_act && rst_hv);
        if (!rst_n) begin
            ref_cnt = 0; ref_pulse = 1'b0;
        end else begin
            ref_pulse = 1'b0;
            if (svc) ref_cnt = 0;
            else if (en) begin
                if (ref_cnt == MAXC) begin ref_cnt = 0; ref_pulse = 1'b1; end
                else ref_cnt = ref_cnt + 1;
            end
        end
    endtask

    // One cycle: inputs already driven at the falling edge
    task automatic step(string tag);
        #1;
        chk("R3 read data", int'(bus_rdata), exp_rdata());
        chk("R7 prescaler clear", int'(presc_clr), int'(stop_mode));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, int'(wdog_rst), int'(ref_pulse));
    endtask

    task automatic idle();
        rst_n = 1'b1; cnt_tick = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = 16'h0100; stop_mode = 1'b0; mon_mode = 1'b0;
        brk_act = 1'b0; irq_hv = 1'b0; rst_hv = 1'b0;
    endtask

    task automatic run_to_term(string tag);
        idle();
        while (ref_cnt != MAXC) step(tag);
    endtask

    // Period from the current state until a request appears
    task automatic measure(string tag, output int n);
        n = 0;
        idle();
        do begin step(tag); n++; end while (!wdog_rst && n < 4 * (MAXC + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        idle(); vec_lo = 8'h5A; rst_n = 1'b0;
        @(negedge clk);
        // R5 reset state
        repeat (3) step("R5 reset");
        chk("R5 reset output", int'(wdog_rst), 0);

        // R2 period and single-cycle request
        measure("R2 timeout", n);
        chk("R2 period", n, MAXC + 1);
        step("R2 single cycle");
        chk("R2 low after pulse", int'(wdog_rst), 0);

        // R1 service mid-count restarts full period
        idle(); repeat (20) step("R1");
        bus_addr = SVC; bus_wr = 1'b1; step("R1 service");
        measure("R1 after service", n);
        chk("R1 full period", n, MAXC + 1);

        // R6 service coinciding with terminal tick
        run_to_term("R6");
        bus_addr = SVC; bus_wr = 1'b1; step("R6 coincident");
        chk("R6 no request", int'(wdog_rst), 0);
        measure("R6 restart", n);
        chk("R6 full period", n, MAXC + 1);

        // R3 / R4 reads and foreign writes do not service
        run_to_term("R4");
        bus_addr = SVC; bus_rd = 1'b1; vec_lo = 8'hC3; cnt_tick = 1'b0; step("R4 read");
        chk("R3 vector byte", int'(bus_rdata), 8'hC3);
        bus_rd = 1'b0; bus_addr = 16'hFFFE; bus_wr = 1'b1; cnt_tick = 1'b0; step("R4 other write");
        bus_addr = 16'h7FFF; step("R4 other write");
        idle(); bus_addr = SVC; bus_rd = 1'b1; step("R4 read at term");
        chk("R4 request still issued", int'(wdog_rst), 1);

        // R10 tick gating
        run_to_term("R10");
        cnt_tick = 1'b0; repeat (15) step("R10 no tick");
        chk("R10 held", int'(wdog_rst), 0);
        idle(); step("R10 tick");
        chk("R10 resumes", int'(wdog_rst), 1);

        // R7 stop freezes
        run_to_term("R7");
        stop_mode = 1'b1; repeat (20) step("R7 stop");
        chk("R7 no request in stop", int'(wdog_rst), 0);
        idle(); step("R7 exit");
        chk("R7 resumes", int'(wdog_rst), 1);

        // R8 monitor mode
        run_to_term("R8");
        mon_mode = 1'b1; irq_hv = 1'b1; repeat (10) step("R8 mon irq_hv");
        irq_hv = 1'b0; rst_hv = 1'b1; repeat (10) step("R8 mon rst_hv");
        chk("R8 held", int'(wdog_rst), 0);
        rst_hv = 1'b0; step("R8 mon alone counts");
        chk("R8 mon alone", int'(wdog_rst), 1);

        // R9 break state
        run_to_term("R9");
        brk_act = 1'b1; rst_hv = 1'b1; repeat (10) step("R9 brk rst_hv");
        chk("R9 held", int'(wdog_rst), 0);
        rst_hv = 1'b0; irq_hv = 1'b1; step("R9 brk irq_hv counts");
        chk("R9 irq_hv only", int'(wdog_rst), 1);

        // R5 reset mid-count
        idle(); repeat (30) step("R5");
        rst_n = 1'b0; step("R5 mid reset");
        measure("R5 after reset", n);
        chk("R5 full period", n, MAXC + 1);

        // Seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            rst_n     = ($urandom % 400) != 0;
            cnt_tick  = ($urandom % 6) != 0;
            bus_addr  = ($urandom % 4 == 0) ? SVC : 16'($urandom);
            bus_wr    = ($urandom % 24) == 0;
            bus_rd    = ($urandom % 3) == 0;
            vec_lo    = 8'($urandom);
            stop_mode = ($urandom % 16) == 0;
            mon_mode  = ($urandom % 8) == 0;
            brk_act   = ($urandom % 8) == 0;
            irq_hv    = ($urandom % 3) == 0;
            rst_hv    = ($urandom % 3) == 0;
            step("R2 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule